// File: doc/BRIEF.md
# Host Interrupt Mask and Status Controller

This block gathers one-cycle event pulses from up to sixteen device sources into sticky status bits and reports them to a host over a single interrupt line. A host reaches the block through a small register bus: it programs a mask, in which a 1 blocks a source, and it reads and clears status. The mask can be written whole or changed through a set alias and a clear alias that touch only the bits written as 1. Status can be read two ways: a peek view that leaves it unchanged, and a take view that returns it and then clears every bit. An acknowledge register clears the bits written as 1.

The interrupt line is asserted while any unmasked status bit is set and the enable input is high. A polarity input selects an active-high or an active-low line. Register reads are combinational: read data is valid in the same cycle as the read enable. Side effects of writes and take reads apply at the next rising clock edge. The register offsets are 0 for the mask, 1 for the mask-set alias, 2 for the mask-clear alias, 3 for peek, 4 for take and 5 for acknowledge.

Top module: `hostirq_ctrl`

## Requirements
- R1: After reset the mask reads 0x0001, both status views read 0 and the interrupt line is inactive.
- R2: A write to offset 0 replaces the whole mask with the written value.
- R3: A write to offset 1 sets each mask bit written as 1 and leaves the bits written as 0 unchanged.
- R4: A write to offset 2 clears each mask bit written as 1 and leaves the bits written as 0 unchanged.
- R5: An event pulse on source i sets status bit i at the next clock edge, and the bit stays set until it is cleared.
- R6: A read at offset 3 returns the status bits and leaves them unchanged.
- R7: A read at offset 4 returns the status bits and then clears all of them at the next clock edge.
- R8: A write to offset 5 clears each status bit written as 1 and leaves the others set.
- R9: When an event and a clear (acknowledge or take read) reach the same bit in the same cycle, the bit ends up set.
- R10: The line is active exactly when irq_enable is high and some status bit is set whose mask bit is 0.
- R11: With irq_active_low at 1 the line is driven low when active and high when inactive; with it at 0 the line is driven high when active.
- R12: Reads at offsets 1, 2 and 5 return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| irq_enable | input | 1 | Allows the interrupt line to become active |
| irq_active_low | input | 1 | 1 selects an active-low line, 0 an active-high line |
| evt_pulse | input | 16 | One-cycle event pulses, one per source |
| reg_addr | input | 3 | Register offset |
| reg_wr | input | 1 | Write enable |
| reg_wdata | input | 16 | Write data |
| reg_rd | input | 1 | Read enable; a take read clears status |
| reg_rdata | output | 16 | Read data, valid while reg_rd is high |
| host_irq | output | 1 | Interrupt line to the host |

## Verification
Assertions check every cycle that a pulsed event is latched and wins over a simultaneous clear, and that acknowledge and take reads leave no unwanted bit set. They also check that the mask aliases set or clear the bits written as 1, that a peek read with no event and no acknowledge changes nothing, and that the line sits at its inactive level when status is empty or the line is disabled. Only the bench scenarios can show the read data returned by each view and each alias, the reset value of the mask, and the effect of the mask and the polarity on the line for given status patterns.

// File: rtl/hostirq_pkg.sv
package hostirq_pkg;

   // Register offsets; the host software depends on these values.
   typedef enum logic [2:0] {
      OFS_MASK  = 3'd0,
      OFS_MSET  = 3'd1,
      OFS_MCLR  = 3'd2,
      OFS_PEEK  = 3'd3,
      OFS_TAKE  = 3'd4,
      OFS_ACK   = 3'd5
   } hirq_ofs_e;

   // Decoded per-access strobes.
   typedef struct packed {
      logic mask_wr;
      logic mask_set;
      logic mask_clr;
      logic ack_wr;
      logic mask_rd;
      logic peek_rd;
      logic take_rd;
   } hirq_strobe_t;

   // Source bit positions.
   localparam int SRC_RXBUF0_DATA = 0;
   localparam int SRC_TX_DATA     = 1;
   localparam int SRC_TX_MOVE     = 2;
   localparam int SRC_RXBUF1_DATA = 3;
   localparam int SRC_RX_MOVE     = 4;
   localparam int SRC_MBOX_A      = 5;
   localparam int SRC_MBOX_B      = 6;
   localparam int SRC_WAKE        = 7;
   localparam int SRC_TRACE_A     = 8;
   localparam int SRC_TRACE_B     = 9;
   localparam int SRC_CMD_DONE    = 10;
   localparam int SRC_INIT_DONE   = 14;

endpackage

// File: rtl/hostirq_decode.sv
module hostirq_decode
   import hostirq_pkg::*;
#(
   parameter int ADDR_W = 3
) (
   input  logic [ADDR_W-1:0] addr,
   input  logic              wr,
   input  logic              rd,
   output hirq_strobe_t      strb
);
   logic       hi_ok;
   hirq_ofs_e  ofs;

   generate
      if (ADDR_W > 3) begin : g_wide
         assign hi_ok = ~|addr[ADDR_W-1:3];
      end else begin : g_narrow
         assign hi_ok = 1'b1;
      end
   endgenerate

   assign ofs = hirq_ofs_e'(addr[2:0]);

   always_comb begin
      strb          = '0;
      strb.mask_wr  = hi_ok && wr && (ofs == OFS_MASK);
      strb.mask_set = hi_ok && wr && (ofs == OFS_MSET);
      strb.mask_clr = hi_ok && wr && (ofs == OFS_MCLR);
      strb.ack_wr   = hi_ok && wr && (ofs == OFS_ACK);
      strb.mask_rd  = hi_ok && rd && (ofs == OFS_MASK);
      strb.peek_rd  = hi_ok && rd && (ofs == OFS_PEEK);
      strb.take_rd  = hi_ok && rd && (ofs == OFS_TAKE);
   end

   // At most one register is addressed per access.
   always_comb begin
      a_r12_one_target: assert ($onehot0({strb.mask_wr, strb.mask_set, strb.mask_clr, strb.ack_wr}));
   end
endmodule

// File: rtl/hostirq_mask.sv
module hostirq_mask #(
   parameter int          NUM_SRC   = 16,
   parameter logic [31:0] MASK_INIT = 32'h0000_0001
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               do_write,
   input  logic               do_set,
   input  logic               do_clr,
   input  logic [NUM_SRC-1:0] wbits,
   output logic [NUM_SRC-1:0] mask
);
   localparam logic [NUM_SRC-1:0] INIT = MASK_INIT[NUM_SRC-1:0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        mask <= INIT;
      else if (do_write) mask <= wbits;
      else if (do_set)   mask <= mask | wbits;
      else if (do_clr)   mask <= mask & ~wbits;
   end

   a_r2_write_whole: assert property (@(posedge clk) disable iff (!rst_n)
      do_write |=> mask == $past(wbits));
   a_r3_set_alias: assert property (@(posedge clk) disable iff (!rst_n)
      do_set |=> ((mask & $past(wbits)) == $past(wbits)) &&
                 ((mask & ~$past(wbits)) == ($past(mask) & ~$past(wbits))));
   a_r4_clr_alias: assert property (@(posedge clk) disable iff (!rst_n)
      do_clr |=> ((mask & $past(wbits)) == '0) &&
                 ((mask & ~$past(wbits)) == ($past(mask) & ~$past(wbits))));
endmodule

// File: rtl/hostirq_status.sv
module hostirq_status #(
   parameter int NUM_SRC = 16
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_SRC-1:0] evt,
   input  logic               take_all,
   input  logic               ack_wr,
   input  logic [NUM_SRC-1:0] ack_bits,
   output logic [NUM_SRC-1:0] status
);
   logic [NUM_SRC-1:0] clr_vec;

   assign clr_vec = take_all ? '1 : (ack_wr ? ack_bits : '0);

   generate
      for (genvar i = 0; i < NUM_SRC; i++) begin : g_bit
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)          status[i] <= 1'b0;
            else if (evt[i])     status[i] <= 1'b1;
            else if (clr_vec[i]) status[i] <= 1'b0;
         end
      end
   endgenerate

   a_r5_r9_event_lands: assert property (@(posedge clk) disable iff (!rst_n)
      |evt |=> (status & $past(evt)) == $past(evt));
   a_r7_take_clears: assert property (@(posedge clk) disable iff (!rst_n)
      take_all |=> (status & ~$past(evt)) == '0);
   a_r8_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_wr && !take_all) |=> ((status & $past(ack_bits) & ~$past(evt)) == '0) &&
         ((status & ~$past(ack_bits)) == (($past(status) | $past(evt)) & ~$past(ack_bits))));
   a_r6_hold_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      (!take_all && !ack_wr && evt == '0) |=> $stable(status));
endmodule

// File: rtl/hostirq_ctrl.sv
module hostirq_ctrl
   import hostirq_pkg::*;
#(
   parameter int          NUM_SRC   = 16,
   parameter int          DATA_W    = 16,
   parameter int          ADDR_W    = 3,
   parameter logic [31:0] MASK_INIT = 32'h0000_0001
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               irq_enable,
   input  logic               irq_active_low,
   input  logic [NUM_SRC-1:0] evt_pulse,
   input  logic [ADDR_W-1:0]  reg_addr,
   input  logic               reg_wr,
   input  logic [DATA_W-1:0]  reg_wdata,
   input  logic               reg_rd,
   output logic [DATA_W-1:0]  reg_rdata,
   output logic               host_irq
);
   generate
      if (NUM_SRC < 1 || NUM_SRC > 32) begin : g_bad_src
         $error("NUM_SRC must lie in 1..32");
      end
      if (DATA_W < NUM_SRC) begin : g_bad_data
         $error("DATA_W must hold every source bit");
      end
      if (ADDR_W < 3) begin : g_bad_addr
         $error("ADDR_W must reach six offsets");
      end
   endgenerate

   hirq_strobe_t       strb;
   logic [NUM_SRC-1:0] wbits;
   logic [NUM_SRC-1:0] mask;
   logic [NUM_SRC-1:0] status;
   logic               pending;
   logic               irq_on;

   assign wbits = reg_wdata[NUM_SRC-1:0];

   hostirq_decode #(.ADDR_W(ADDR_W)) u_decode (
      .addr (reg_addr),
      .wr   (reg_wr),
      .rd   (reg_rd),
      .strb (strb)
   );

   hostirq_mask #(.NUM_SRC(NUM_SRC), .MASK_INIT(MASK_INIT)) u_mask (
      .clk      (clk),
      .rst_n    (rst_n),
      .do_write (strb.mask_wr),
      .do_set   (strb.mask_set),
      .do_clr   (strb.mask_clr),
      .wbits    (wbits),
      .mask     (mask)
   );

   hostirq_status #(.NUM_SRC(NUM_SRC)) u_status (
      .clk      (clk),
      .rst_n    (rst_n),
      .evt      (evt_pulse),
      .take_all (strb.take_rd),
      .ack_wr   (strb.ack_wr),
      .ack_bits (wbits),
      .status   (status)
   );

   always_comb begin
      reg_rdata = '0;
      if (strb.mask_rd)                      reg_rdata[NUM_SRC-1:0] = mask;
      else if (strb.peek_rd || strb.take_rd) reg_rdata[NUM_SRC-1:0] = status;
   end

   assign pending  = |(status & ~mask);
   assign irq_on   = irq_enable & pending;
   assign host_irq = irq_on ^ irq_active_low;

   a_r10_idle_when_empty: assert property (@(posedge clk) disable iff (!rst_n)
      (status == '0) |-> host_irq == irq_active_low);
   a_r11_idle_when_disabled: assert property (@(posedge clk) disable iff (!rst_n)
      !irq_enable |-> host_irq == irq_active_low);
   a_r1_reset_quiet: assert property (@(posedge clk)
      $rose(rst_n) |-> status == '0);
endmodule

// File: tb/hostirq_ctrl_tb.sv
module hostirq_ctrl_tb;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        irq_enable = 1'b1;
   logic        irq_active_low = 1'b0;
   logic [15:0] evt_pulse = '0;
   logic [2:0]  reg_addr = '0;
   logic        reg_wr = 1'b0;
   logic [15:0] reg_wdata = '0;
   logic        reg_rd = 1'b0;
   logic [15:0] reg_rdata;
   logic        host_irq;

   int checks = 0;
   int errors = 0;
   logic [15:0] exp_q[$];
   string       tag_q[$];

   always #(CLK_PERIOD/2) clk = ~clk;

   hostirq_ctrl u_dut (
      .clk            (clk),
      .rst_n          (rst_n),
      .irq_enable     (irq_enable),
      .irq_active_low (irq_active_low),
      .evt_pulse      (evt_pulse),
      .reg_addr       (reg_addr),
      .reg_wr         (reg_wr),
      .reg_wdata      (reg_wdata),
      .reg_rd         (reg_rd),
      .reg_rdata      (reg_rdata),
      .host_irq       (host_irq)
   );

   // Monitor: compares read data with the scoreboard.
   always begin
      @(negedge clk);
      #(CLK_PERIOD/4);
      if (reg_rd) begin
         logic [15:0] e;
         string t;
         e = exp_q.pop_front();
         t = tag_q.pop_front();
         checks++;
         if (reg_rdata !== e) begin
            errors++;
            $display("FAIL %s: rdata actual %h expected %h", t, reg_rdata, e);
         end
      end
   end

   task automatic do_rd(input logic [2:0] a, input logic [15:0] e, input string t,
                        input logic [15:0] ev = '0);
      @(negedge clk);
      reg_rd = 1'b1; reg_wr = 1'b0; reg_addr = a; evt_pulse = ev;
      exp_q.push_back(e); tag_q.push_back(t);
   endtask

   task automatic do_wr(input logic [2:0] a, input logic [15:0] d,
                        input logic [15:0] ev = '0);
      @(negedge clk);
      reg_rd = 1'b0; reg_wr = 1'b1; reg_addr = a; reg_wdata = d; evt_pulse = ev;
   endtask

   task automatic pulse(input logic [15:0] ev);
      @(negedge clk);
      reg_rd = 1'b0; reg_wr = 1'b0; evt_pulse = ev;
   endtask

   task automatic chk_irq(input logic e, input string t);
      @(negedge clk);
      reg_rd = 1'b0; reg_wr = 1'b0; evt_pulse = '0;
      #(CLK_PERIOD/4);
      checks++;
      if (host_irq !== e) begin
         errors++;
         $display("FAIL %s: host_irq actual %b expected %b", t, host_irq, e);
      end
   endtask

   initial begin
      #(CLK_PERIOD*20000);
      errors++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R1 reset state
      do_rd(3'd0, 16'h0001, "R1 mask reset");
      do_rd(3'd3, 16'h0000, "R1 peek reset");
      do_rd(3'd4, 16'h0000, "R1 take reset");
      chk_irq(1'b0, "R1 line inactive");
      // R5 latch of a masked source; R10 stays quiet
      pulse(16'h0001);
      chk_irq(1'b0, "R10 masked source");
      do_rd(3'd3, 16'h0001, "R5 sticky bit");
      do_rd(3'd3, 16'h0001, "R6 peek unchanged");
      // R10 unmasked source
      pulse(16'h0008);
      chk_irq(1'b1, "R10 unmasked active");
      irq_enable = 1'b0;
      chk_irq(1'b0, "R10 disabled");
      irq_enable = 1'b1;
      // R11 polarity
      irq_active_low = 1'b1;
      chk_irq(1'b0, "R11 active low asserted");
      do_wr(3'd5, 16'h0008);
      do_rd(3'd3, 16'h0001, "R8 ack one bit");
      chk_irq(1'b1, "R11 active low idle");
      irq_active_low = 1'b0;
      // R3 R4 R2 mask paths
      do_wr(3'd1, 16'h0F00);
      do_rd(3'd0, 16'h0F01, "R3 set alias");
      do_wr(3'd2, 16'h0101);
      do_rd(3'd0, 16'h0E00, "R4 clear alias");
      do_wr(3'd0, 16'h1234);
      do_rd(3'd0, 16'h1234, "R2 whole write");
      // R12 aliases read zero
      do_rd(3'd1, 16'h0000, "R12 set alias read");
      do_rd(3'd2, 16'h0000, "R12 clear alias read");
      do_rd(3'd5, 16'h0000, "R12 ack read");
      // R7 take read
      pulse(16'h00F0);
      do_rd(3'd4, 16'h00F1, "R7 take returns");
      do_rd(3'd3, 16'h0000, "R7 take cleared");
      // R9 event beats ack and take
      do_wr(3'd5, 16'h0002, 16'h0002);
      do_rd(3'd3, 16'h0002, "R9 event over ack");
      do_rd(3'd4, 16'h0002, "R9 take before event", 16'h4000);
      do_rd(3'd3, 16'h4000, "R9 event over take");
      chk_irq(1'b1, "R10 new source active");
      do_wr(3'd1, 16'h4000);
      chk_irq(1'b0, "R10 masked by set alias");
      repeat (3) @(negedge clk);
      if (exp_q.size() != 0) begin
         errors++;
         $display("FAIL scoreboard: actual %0d left expected 0", exp_q.size());
      end
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule